// File: doc/BRIEF.md
# Start-Stop Serial Frame Transmitter

This block turns a small parallel word into a short serial burst on one line. A falling edge on the trigger input starts a frame. The frame is a high start bit, then the data bits with the least significant bit first, then a low stop bit. Each bit takes exactly one clock cycle, so the bit rate equals the clock rate. The receiver at the far end samples the line with the same clock.

The trigger input is registered once. A falling edge is found by comparing that registered sample with the live input level, so a trigger pulse of any length works. The data word is copied into a holding register on the clock edge that accepts the trigger. Changes to the data inputs during a frame therefore do not alter the bits already in flight. Trigger edges that arrive while a frame is being sent are dropped. Between frames the line rests low, which is the same level as the stop bit.

Top module: `serial_frame_tx`

## Requirements
- R1: While reset is high, and on the first cycle after it is released, `ser` is 0. Holding `go` low through reset and afterwards starts no frame.
- R2: A 1-to-0 change of `go` that is seen at a rising clock edge while the block is idle starts a frame. `ser` is 1 (the start bit) for the clock cycle that follows that edge.
- R3: After the start bit, `ser` carries `data_in[0]`, then `data_in[1]`, up to `data_in[DATA_W-1]`, each for one cycle. After these it carries one cycle of 0 (the stop bit). A frame therefore lasts DATA_W+2 cycles.
- R4: The data word is captured on the edge that starts the frame. Changes to `data_in` after that edge do not change the frame being sent.
- R5: A falling edge of `go` seen during the start bit or any data bit is ignored. It neither restarts nor extends the frame, and no frame follows it.
- R6: When no frame is being sent, `ser` is 0.
- R7: A frame starts whatever the length of the high `go` pulse before the fall, from one cycle to many. A rising edge of `go` starts nothing.
- R8: A falling edge of `go` seen at the edge that ends the stop bit is ignored. A falling edge seen at the next edge after that starts a new frame at once, so frames can be sent back to back with one idle cycle between them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; one bit time per cycle |
| rst | input | 1 | Synchronous reset, active high |
| go | input | 1 | Trigger; a falling edge requests a frame |
| data_in | input | DATA_W | Word to send; bit 0 goes first |
| ser | output | 1 | Serial line output |

## Verification
The hardest cases to reach from the ports are the timing edges around the stop bit. These are a trigger fall that lands on exactly the edge ending the stop bit, which must be dropped, and one that lands a single edge later, which must start the next frame. The bench reaches them by counting negative clock edges from the trigger fall of a first frame. It then drops `go` again on a chosen edge, after raising it earlier during that frame. Other stimulus does the same mid-frame to check that busy-time edges are rejected, and scrambles `data_in` during a frame to check the capture.

// File: rtl/txf_pkg.sv
package txf_pkg;

    typedef enum logic [1:0] {
        TXF_IDLE  = 2'd0,
        TXF_START = 2'd1,
        TXF_DATA  = 2'd2,
        TXF_STOP  = 2'd3
    } txf_state_e;

    localparam logic LVL_START = 1'b1;
    localparam logic LVL_STOP  = 1'b0;
    localparam logic LVL_REST  = 1'b0;

    function automatic int unsigned idx_width(input int unsigned w);
        return (w > 1) ? $clog2(w) : 1;
    endfunction

    function automatic int unsigned frame_cycles(input int unsigned w);
        return w + 2;
    endfunction

    function automatic logic line_level(input txf_state_e st, input logic data_bit);
        logic lvl;
        unique case (st)
            TXF_START: lvl = LVL_START;
            TXF_DATA:  lvl = data_bit;
            TXF_STOP:  lvl = LVL_STOP;
            default:   lvl = LVL_REST;
        endcase
        return lvl;
    endfunction

endpackage

// File: rtl/txf_go_fall.sv
module txf_go_fall (
    input  logic clk,
    input  logic rst,
    input  logic go_i,
    output logic fall_o
);
    logic go_prev_q;

    always_ff @(posedge clk) begin
        if (rst) go_prev_q <= 1'b0;
        else     go_prev_q <= go_i;
    end

    assign fall_o = go_prev_q & ~go_i;

    // R7: two falls can never be seen on adjacent edges
    p_fall_single_r7: assert property (@(posedge clk) disable iff (rst)
        fall_o |=> !fall_o);

endmodule

// File: rtl/txf_word_hold.sv
module txf_word_hold #(
    parameter int unsigned DATA_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_i,
    input  logic [DATA_W-1:0] d_i,
    output logic [DATA_W-1:0] q_o
);
    always_ff @(posedge clk) begin
        if (rst)         q_o <= '0;
        else if (load_i) q_o <= d_i;
    end

    p_hold_stable_r4: assert property (@(posedge clk) disable iff (rst)
        !load_i |=> $stable(q_o));

endmodule

// File: rtl/txf_sequencer.sv
module txf_sequencer
    import txf_pkg::*;
#(
    parameter int unsigned DATA_W = 3,
    localparam int unsigned IDX_W = idx_width(DATA_W)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             fall_i,
    output logic             load_o,
    output txf_state_e       state_o,
    output logic [IDX_W-1:0] idx_o
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DATA_W - 1);

    txf_state_e       state_q, state_d;
    logic [IDX_W-1:0] idx_q, idx_d;

    assign load_o = (state_q == TXF_IDLE) && fall_i;

    always_comb begin
        state_d = state_q;
        idx_d   = idx_q;
        unique case (state_q)
            TXF_IDLE: begin
                idx_d = '0;
                if (fall_i) state_d = TXF_START;
            end
            TXF_START: begin
                state_d = TXF_DATA;
                idx_d   = '0;
            end
            TXF_DATA: begin
                if (idx_q == LAST_IDX) begin
                    state_d = TXF_STOP;
                    idx_d   = '0;
                end else begin
                    idx_d = idx_q + 1'b1;
                end
            end
            TXF_STOP: state_d = TXF_IDLE;
            default:  state_d = TXF_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= TXF_IDLE;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
        end
    end

    assign state_o = state_q;
    assign idx_o   = idx_q;

    p_fall_starts_r2: assert property (@(posedge clk) disable iff (rst)
        (state_q == TXF_IDLE && fall_i) |=> (state_q == TXF_START));

    p_busy_no_restart_r5: assert property (@(posedge clk) disable iff (rst)
        (state_q != TXF_IDLE) |=> (state_q != TXF_START));

    p_data_walk_r3: assert property (@(posedge clk) disable iff (rst)
        (state_q == TXF_DATA && idx_q != LAST_IDX) |=>
            (state_q == TXF_DATA && idx_q == $past(idx_q) + 1'b1));

    p_start_to_data_r3: assert property (@(posedge clk) disable iff (rst)
        (state_q == TXF_START) |=> (state_q == TXF_DATA && idx_q == '0));

    p_stop_then_idle_r8: assert property (@(posedge clk) disable iff (rst)
        (state_q == TXF_STOP) |=> (state_q == TXF_IDLE));

endmodule

// File: rtl/serial_frame_tx.sv
module serial_frame_tx
    import txf_pkg::*;
#(
    parameter int unsigned DATA_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              go,
    input  logic [DATA_W-1:0] data_in,
    output logic              ser
);
    localparam int unsigned IDX_W = idx_width(DATA_W);

    logic              fall;
    logic              load;
    txf_state_e        state;
    logic [IDX_W-1:0]  idx;
    logic [DATA_W-1:0] word_q;

    txf_go_fall u_fall (
        .clk    (clk),
        .rst    (rst),
        .go_i   (go),
        .fall_o (fall)
    );

    txf_sequencer #(.DATA_W(DATA_W)) u_seq (
        .clk     (clk),
        .rst     (rst),
        .fall_i  (fall),
        .load_o  (load),
        .state_o (state),
        .idx_o   (idx)
    );

    txf_word_hold #(.DATA_W(DATA_W)) u_hold (
        .clk    (clk),
        .rst    (rst),
        .load_i (load),
        .d_i    (data_in),
        .q_o    (word_q)
    );

    logic cur_bit;
    always_comb begin
        cur_bit = 1'b0;
        for (int i = 0; i < DATA_W; i++) begin
            if (IDX_W'(i) == idx) cur_bit = word_q[i];
        end
    end

    assign ser = line_level(state, cur_bit);

    p_reset_low_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (ser == 1'b0));

    p_start_bit_r2: assert property (@(posedge clk) disable iff (rst)
        load |=> ser);

    p_data_bit_r4: assert property (@(posedge clk) disable iff (rst)
        load |=> ##1 (ser == $past(data_in[0], 2)));

endmodule

// File: tb/test_serial_frame_tx.sv
module test_serial_frame_tx;
    localparam int W = 3;
    localparam int FL = W + 2;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         go = 1'b0;
    logic [W-1:0] data_in = '0;
    logic         ser;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    serial_frame_tx #(.DATA_W(W)) i_serial_frame_tx (
        .clk(clk), .rst(rst), .go(go), .data_in(data_in), .ser(ser)
    );

    task automatic check(input string tag, input logic [FL-1:0] act, input logic [FL-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    function automatic logic [FL-1:0] frame_of(input logic [W-1:0] d);
        logic [FL-1:0] f;
        f[0] = 1'b1;
        for (int i = 0; i < W; i++) f[i+1] = d[i];
        f[FL-1] = 1'b0;
        return f;
    endfunction

    // go is already high; drop it and read the frame
    task automatic drop_and_read(output logic [FL-1:0] got);
        @(negedge clk); go = 1'b0;
        for (int i = 0; i < FL; i++) begin
            @(negedge clk); got[i] = ser;
        end
    endtask

    task automatic quiet_for(input int n, output logic [FL-1:0] acc);
        acc = '0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk); acc[i % FL] = acc[i % FL] | ser;
        end
    endtask

    task automatic t_reset;
        logic [FL-1:0] q;
        rst = 1'b1; go = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 ser during reset", {{(FL-1){1'b0}}, ser}, '0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 ser after release", {{(FL-1){1'b0}}, ser}, '0);
        quiet_for(8, q);
        check("R1 go low gives no frame", q, '0);
    endtask

    task automatic t_patterns;
        logic [FL-1:0] got;
        logic [W-1:0] pats [5] = '{3'b101, 3'b000, 3'b111, 3'b110, 3'b011};
        foreach (pats[k]) begin
            data_in = pats[k];
            @(negedge clk); go = 1'b1;
            drop_and_read(got);
            check($sformatf("R3 R2 frame for %b", pats[k]), got, frame_of(pats[k]));
            quiet_for(4, got);
            check("R6 line rests low", got, '0);
        end
    endtask

    task automatic t_data_change;
        logic [FL-1:0] got;
        data_in = 3'b010;
        @(negedge clk); go = 1'b1;
        @(negedge clk); go = 1'b0;
        for (int i = 0; i < FL; i++) begin
            @(negedge clk); got[i] = ser;
            data_in = ~data_in;
        end
        check("R4 data held during frame", got, frame_of(3'b010));
    endtask

    task automatic t_busy_fall;
        logic [FL-1:0] got;
        data_in = 3'b100;
        @(negedge clk); go = 1'b1;
        @(negedge clk); go = 1'b0;
        @(negedge clk); got[0] = ser; go = 1'b1;
        @(negedge clk); got[1] = ser; go = 1'b0;
        for (int i = 2; i < FL; i++) begin
            @(negedge clk); got[i] = ser;
            go = ~go;
        end
        go = 1'b0;
        check("R5 busy falls ignored", got, frame_of(3'b100));
        quiet_for(8, got);
        check("R5 no frame after busy fall", got, '0);
    endtask

    task automatic t_pulse_widths;
        logic [FL-1:0] got;
        data_in = 3'b011;
        @(negedge clk); go = 1'b1;
        repeat (20) @(negedge clk);
        drop_and_read(got);
        check("R7 long high pulse", got, frame_of(3'b011));
        quiet_for(3, got);
        data_in = 3'b001;
        @(negedge clk); go = 1'b1;
        quiet_for(6, got);
        check("R7 rising edge starts nothing", got, '0);
        drop_and_read(got);
        check("R7 fall after held high", got, frame_of(3'b001));
    endtask

    task automatic t_back_to_back;
        logic [FL-1:0] got;
        data_in = 3'b110;
        @(negedge clk); go = 1'b1;
        @(negedge clk); go = 1'b0;
        for (int i = 0; i < FL; i++) begin
            @(negedge clk); got[i] = ser;
            if (i == 0) go = 1'b1;
        end
        go = 1'b0;
        check("R8 first frame", got, frame_of(3'b110));
        quiet_for(8, got);
        check("R8 fall at stop end ignored", got, '0);

        data_in = 3'b101;
        @(negedge clk); go = 1'b1;
        @(negedge clk); go = 1'b0;
        for (int i = 0; i < FL; i++) begin
            @(negedge clk); got[i] = ser;
            if (i == 0) go = 1'b1;
        end
        data_in = 3'b011;
        @(negedge clk);
        check("R8 idle gap low", {{(FL-1){1'b0}}, ser}, '0);
        go = 1'b0;
        for (int i = 0; i < FL; i++) begin
            @(negedge clk); got[i] = ser;
        end
        check("R8 frame after one idle cycle", got, frame_of(3'b011));
    endtask

    task automatic finish_run;
        if (!finished) begin
            finished = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        t_reset;
        t_patterns;
        t_data_change;
        t_busy_fall;
        t_pulse_widths;
        t_back_to_back;
        finish_run;
    end

    initial begin
        repeat (50000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run;
    end

endmodule